// File: doc/BRIEF.md
# Neural Network Training Sequencer

This block is the control core of a small neural-network engine. When reset is asserted it returns to its initial state. Once reset is released, it spends one cycle per weight filling the engine's weight memory with pseudo-random starting values. The values come from a 16-bit linear feedback shift register, and each is scaled so that it lies in the signed range [-1, 1). The controller then waits in an idle state. From idle, a start pulse launches one of two activities, chosen by a mode input. The first is a training loop. The second is a single inference pass over the pattern set.

During training, the datapath reports an error value for every pattern it processes. The sequencer sums these values over each epoch. On the last pattern of an epoch it compares the epoch total with a threshold. If the total is below the threshold, training ends with a converged verdict. If the epoch budget is used up first, training ends with a not-converged verdict. The arithmetic of the neurons themselves lies outside this block. The block only sequences the work, seeds the weights and judges convergence.

Top module: `nn_train_seq`

## Requirements
- R1: An active-high asynchronous reset places the controller in its initialization state at once. While reset is high, `init_busy` is 1, `w_we` is 0, `epoch_count` is 0, `last_err` is 0, and both verdict flags are 0.
- R2: After reset is released, `w_we` stays high for exactly N_WEIGHTS consecutive cycles. `w_addr` runs 0, 1, 2, … N_WEIGHTS-1 during those cycles, one address per cycle.
- R3: The LFSR state starts at SEED (default 0xACE1). Each step shifts the state right by one bit. When the bit shifted out is 1, the new state is XORed with the mask 0xB400. The k-th write (counting from 0) carries the k-th state divided by two with the sign kept (Q1.14 format, value in [-1, 1)), so bits 15 and 14 of `w_data` are always equal.
- R4: In the cycle after the last weight write, `idle_flag` is 1 and no further writes occur.
- R5: While the controller is idle, `start`=1 with `mode_train`=1 moves it to training (`train_busy`=1). `start`=1 with `mode_train`=0 moves it to run (`run_busy`=1). While the controller is busy, `start` is ignored.
- R6: In training, every `pat_err_valid` cycle adds `pat_err` to the epoch sum. An epoch ends on a valid pattern with `pat_last`=1. At that point `last_err` takes the epoch total including that pattern, `epoch_count` increases by one, and the sum restarts from 0.
- R7: When an epoch total is strictly below `err_limit`, the controller returns to idle with `converged`=1 and `not_converged`=0.
- R8: When MAX_EPOCHS epochs (default 8) end without convergence, the controller returns to idle with `not_converged`=1 and `epoch_count`=MAX_EPOCHS. Starting a new training run clears both verdict flags and `epoch_count`.
- R9: In run state, pattern errors are not accumulated and leave `last_err` unchanged. A valid pattern with `pat_last`=1 returns the controller to idle.
- R10: Exactly one of `init_busy`, `idle_flag`, `train_busy` and `run_busy` is 1 at any time.
- R11: The epoch sum saturates at 2^ERR_W-1 and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| mode_train | input | 1 | 1 selects training, 0 selects run (sampled when start is seen in idle) |
| start | input | 1 | Launch request, honoured only when idle |
| err_limit | input | ERR_W | Convergence threshold for an epoch total |
| pat_err_valid | input | 1 | A pattern result is present this cycle |
| pat_err | input | ERR_W | Unsigned error of that pattern |
| pat_last | input | 1 | The pattern is the last one of the set |
| w_we | output | 1 | Weight memory write enable |
| w_addr | output | $clog2(N_WEIGHTS) | Weight memory address |
| w_data | output | 16 | Initial weight, signed Q1.14 |
| init_busy | output | 1 | Initialization in progress |
| idle_flag | output | 1 | Waiting for start |
| train_busy | output | 1 | Training loop active |
| run_busy | output | 1 | Inference pass active |
| converged | output | 1 | Last training run met the threshold |
| not_converged | output | 1 | Last training run hit the epoch limit |
| epoch_count | output | $clog2(MAX_EPOCHS+1) | Epochs completed in the current or last training run |
| last_err | output | ERR_W | Total error of the most recent completed epoch |

## Verification
The embedded properties assume that the datapath presents `pat_err_valid` only while the controller is training or running. They also assume that `mode_train` and `err_limit` hold steady around the cycles in which they are used. The bench changes all inputs on the falling clock edge, so they settle well before the rising edge that samples them. It raises `pat_err_valid` only after it has observed `train_busy` or `run_busy`, and it changes the threshold only while the controller is idle. It also asserts the asynchronous reset between clock edges in the middle of a training run, so that the restart properties are exercised from an arbitrary state.

// File: rtl/nn_train_pkg.sv
package nn_train_pkg;

  typedef enum logic [1:0] {
    CTL_INIT  = 2'd0,
    CTL_IDLE  = 2'd1,
    CTL_TRAIN = 2'd2,
    CTL_RUN   = 2'd3
  } ctl_state_t;

  // One Galois step: shift right, fold the mask in when a one falls out.
  function automatic logic [15:0] lfsr_next(input logic [15:0] s, input logic [15:0] mask);
    return {1'b0, s[15:1]} ^ (s[0] ? mask : 16'h0000);
  endfunction

  // Read the state as Q0.15 and halve it into Q1.14, so the value stays in [-1, 1).
  function automatic logic [15:0] lfsr_to_q114(input logic [15:0] s);
    return {s[15], s[15:1]};
  endfunction

endpackage

// File: rtl/nn_lfsr_gen.sv
module nn_lfsr_gen
  import nn_train_pkg::*;
#(
  parameter logic [15:0] SEED = 16'hACE1,
  parameter logic [15:0] MASK = 16'hB400
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        step,
  output logic [15:0] weight
);

  logic [15:0] lfsr_q;

  always_ff @(posedge clk or posedge rst) begin
    if (rst)       lfsr_q <= SEED;
    else if (step) lfsr_q <= lfsr_next(lfsr_q, MASK);
  end

  assign weight = lfsr_to_q114(lfsr_q);

  // R3: a maximal-length register never falls into the all-zero lock state
  assert_lfsr_nonzero_R3: assert property (@(posedge clk) disable iff (rst)
    lfsr_q != 16'h0000);

endmodule

// File: rtl/nn_epoch_acc.sv
module nn_epoch_acc #(
  parameter int ERR_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             add_en,
  input  logic [ERR_W-1:0] add_val,
  output logic [ERR_W-1:0] acc_q,
  output logic [ERR_W-1:0] sum_now
);

  function automatic logic [ERR_W-1:0] sat_add(input logic [ERR_W-1:0] a, input logic [ERR_W-1:0] b);
    logic [ERR_W:0] t;
    t = {1'b0, a} + {1'b0, b};
    return t[ERR_W] ? {ERR_W{1'b1}} : t[ERR_W-1:0];
  endfunction

  assign sum_now = sat_add(acc_q, add_val);

  always_ff @(posedge clk or posedge rst) begin
    if (rst)         acc_q <= '0;
    else if (clr)    acc_q <= '0;
    else if (add_en) acc_q <= sum_now;
  end

  // R6/R11: between clears the sum only grows; it never wraps
  assert_acc_monotone_R11: assert property (@(posedge clk) disable iff (rst)
    !$past(clr) |-> acc_q >= $past(acc_q));

endmodule

// File: rtl/nn_train_seq.sv
module nn_train_seq
  import nn_train_pkg::*;
#(
  parameter int          N_WEIGHTS  = 32,
  parameter int          MAX_EPOCHS = 8,
  parameter int          ERR_W      = 24,
  parameter logic [15:0] SEED       = 16'hACE1
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              mode_train,
  input  logic                              start,
  input  logic [ERR_W-1:0]                  err_limit,
  input  logic                              pat_err_valid,
  input  logic [ERR_W-1:0]                  pat_err,
  input  logic                              pat_last,
  output logic                              w_we,
  output logic [$clog2(N_WEIGHTS)-1:0]      w_addr,
  output logic [15:0]                       w_data,
  output logic                              init_busy,
  output logic                              idle_flag,
  output logic                              train_busy,
  output logic                              run_busy,
  output logic                              converged,
  output logic                              not_converged,
  output logic [$clog2(MAX_EPOCHS+1)-1:0]   epoch_count,
  output logic [ERR_W-1:0]                  last_err
);

  localparam int AW  = $clog2(N_WEIGHTS);
  localparam int EPW = $clog2(MAX_EPOCHS+1);
  localparam logic [AW-1:0]  LAST_ADDR  = AW'(N_WEIGHTS-1);
  localparam logic [EPW-1:0] LAST_EPOCH = EPW'(MAX_EPOCHS-1);

  ctl_state_t        state_q, state_d;
  logic [AW-1:0]     addr_q;
  logic [EPW-1:0]    epoch_q;
  logic [ERR_W-1:0]  last_err_q;
  logic              conv_q, nconv_q;

  // Named internal events
  logic in_init, in_idle, in_train, in_run;
  logic init_done, go_train, go_run;
  logic epoch_end, epoch_hit, epoch_cap, run_end;
  logic acc_clr, acc_add;
  logic [ERR_W-1:0] acc_q, epoch_total;

  assign in_init  = (state_q == CTL_INIT);
  assign in_idle  = (state_q == CTL_IDLE);
  assign in_train = (state_q == CTL_TRAIN);
  assign in_run   = (state_q == CTL_RUN);

  assign init_done = in_init && (addr_q == LAST_ADDR);
  assign go_train  = in_idle && start && mode_train;
  assign go_run    = in_idle && start && !mode_train;
  assign epoch_end = in_train && pat_err_valid && pat_last;
  assign epoch_hit = epoch_end && (epoch_total < err_limit);
  assign epoch_cap = epoch_end && !epoch_hit && (epoch_q == LAST_EPOCH);
  assign run_end   = in_run && pat_err_valid && pat_last;

  assign acc_clr = go_train || epoch_end;
  assign acc_add = in_train && pat_err_valid && !pat_last;

  nn_lfsr_gen #(.SEED(SEED), .MASK(16'hB400)) u_lfsr (
    .clk    (clk),
    .rst    (rst),
    .step   (in_init),
    .weight (w_data)
  );

  nn_epoch_acc #(.ERR_W(ERR_W)) u_acc (
    .clk     (clk),
    .rst     (rst),
    .clr     (acc_clr),
    .add_en  (acc_add),
    .add_val (pat_err),
    .acc_q   (acc_q),
    .sum_now (epoch_total)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      CTL_INIT:  if (init_done) state_d = CTL_IDLE;
      CTL_IDLE:  begin
        if (go_train)    state_d = CTL_TRAIN;
        else if (go_run) state_d = CTL_RUN;
      end
      CTL_TRAIN: if (epoch_hit || epoch_cap) state_d = CTL_IDLE;
      CTL_RUN:   if (run_end) state_d = CTL_IDLE;
      default:   state_d = CTL_INIT;
    endcase
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      state_q    <= CTL_INIT;
      addr_q     <= '0;
      epoch_q    <= '0;
      last_err_q <= '0;
      conv_q     <= 1'b0;
      nconv_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (in_init) addr_q <= addr_q + 1'b1;
      if (go_train) begin
        epoch_q <= '0;
        conv_q  <= 1'b0;
        nconv_q <= 1'b0;
      end
      if (epoch_end) begin
        epoch_q    <= epoch_q + 1'b1;
        last_err_q <= epoch_total;
      end
      if (epoch_hit) conv_q  <= 1'b1;
      if (epoch_cap) nconv_q <= 1'b1;
    end
  end

  assign w_we          = in_init && !rst;
  assign w_addr        = addr_q;
  assign init_busy     = in_init;
  assign idle_flag     = in_idle;
  assign train_busy    = in_train;
  assign run_busy      = in_run;
  assign converged     = conv_q;
  assign not_converged = nconv_q;
  assign epoch_count   = epoch_q;
  assign last_err      = last_err_q;

  // R10: exactly one activity flag
  assert_one_activity_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot({init_busy, idle_flag, train_busy, run_busy}));

  // R3: initial weights keep bits 15 and 14 equal, so they lie in [-1, 1)
  assert_weight_range_R3: assert property (@(posedge clk) disable iff (rst)
    w_we |-> (w_data[15] == w_data[14]));

  // R2: back-to-back writes step the address by one
  assert_addr_step_R2: assert property (@(posedge clk) disable iff (rst)
    (w_we && $past(w_we)) |-> (w_addr == $past(w_addr) + 1'b1));

  // R4: leaving initialization always lands in idle
  assert_init_to_idle_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(init_busy) |-> idle_flag);

  // R8: the epoch counter never passes its limit
  assert_epoch_cap_R8: assert property (@(posedge clk) disable iff (rst)
    epoch_count <= EPW'(MAX_EPOCHS));

  // R7: verdicts are mutually exclusive
  assert_verdict_excl_R7: assert property (@(posedge clk) disable iff (rst)
    !(converged && not_converged));

  // R9: a run cycle never alters the stored epoch error
  assert_run_keeps_err_R9: assert property (@(posedge clk) disable iff (rst)
    $past(run_busy) |-> (last_err == $past(last_err)));

endmodule

// File: tb/tb_nn_train_seq.sv
module tb_nn_train_seq;

  localparam int          N    = 32;
  localparam int          MAXE = 8;
  localparam int          EW   = 24;
  localparam logic [15:0] SD   = 16'hACE1;
  localparam int          AW   = $clog2(N);
  localparam int          EPW  = $clog2(MAXE+1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_train = 1'b0, start = 1'b0;
  logic [EW-1:0] err_limit = '0;
  logic pat_err_valid = 1'b0, pat_last = 1'b0;
  logic [EW-1:0] pat_err = '0;
  logic w_we;
  logic [AW-1:0] w_addr;
  logic [15:0] w_data;
  logic init_busy, idle_flag, train_busy, run_busy, converged, not_converged;
  logic [EPW-1:0] epoch_count;
  logic [EW-1:0] last_err;

  int n_vec = 0;
  int n_bad = 0;
  int n_writes = 0;
  int cycles = 0;
  logic [31:0] exp_q[$];

  always #5 clk = ~clk;

  nn_train_seq #(.N_WEIGHTS(N), .MAX_EPOCHS(MAXE), .ERR_W(EW), .SEED(SD)) dut (
    .clk(clk), .rst(rst), .mode_train(mode_train), .start(start),
    .err_limit(err_limit), .pat_err_valid(pat_err_valid), .pat_err(pat_err),
    .pat_last(pat_last), .w_we(w_we), .w_addr(w_addr), .w_data(w_data),
    .init_busy(init_busy), .idle_flag(idle_flag), .train_busy(train_busy),
    .run_busy(run_busy), .converged(converged), .not_converged(not_converged),
    .epoch_count(epoch_count), .last_err(last_err)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  // Driver side: expected write stream, computed as integer arithmetic
  task automatic push_init_stream();
    int s;
    s = SD;
    exp_q.delete();
    for (int i = 0; i < N; i++) begin
      int w;
      w = (s >= 32768) ? (s - 65536) : s;   // signed view of the state
      w = (w < 0) ? -((-w + 1) / 2) : w / 2; // halve, rounding toward minus infinity
      exp_q.push_back({i[15:0], w[15:0]});
      if (s % 2 == 1) s = (s / 2) ^ 32'hB400;
      else            s = s / 2;
    end
  endtask

  // Monitor: pop and compare every write the design makes
  always @(negedge clk) begin
    cycles++;
    if (!rst && w_we) begin
      n_writes++;
      if (exp_q.size() == 0) begin
        check("R4 unexpected write", 1, 0);
      end else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        check("R2 address", w_addr, e[31:16]);
        check("R3 weight", w_data, e[15:0]);
      end
    end
    if (cycles > 100000) begin
      check("watchdog", 1, 0);
      report();
    end
  end

  task automatic do_reset();
    rst = 1'b1;
    #3;
    check("R1 init_busy in reset", init_busy, 1);
    check("R1 no write in reset", w_we, 0);
    check("R1 epoch_count", epoch_count, 0);
    check("R1 last_err", last_err, 0);
    check("R1 verdicts", {converged, not_converged}, 0);
    push_init_stream();
    n_writes = 0;
    @(posedge clk); #2;
    rst = 1'b0;
    repeat (N + 2) @(negedge clk);
    check("R2 write count", n_writes, N);
    check("R2 stream consumed", exp_q.size(), 0);
    check("R4 idle after init", idle_flag, 1);
    check("R10 one flag", {init_busy, train_busy, run_busy}, 0);
  endtask

  task automatic launch(input logic tr);
    @(negedge clk);
    mode_train = tr; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic send(input int err, input logic last);
    @(negedge clk);
    pat_err_valid = 1'b1; pat_err = EW'(err); pat_last = last;
    @(negedge clk);
    pat_err_valid = 1'b0; pat_last = 1'b0;
  endtask

  initial begin
    do_reset();

    // Run pass: errors ignored, returns to idle on last
    launch(1'b0);
    check("R5 run flag", run_busy, 1);
    send(100, 1'b0);
    check("R9 run stays", run_busy, 1);
    send(200, 1'b1);
    check("R9 run ends in idle", idle_flag, 1);
    check("R9 last_err untouched", last_err, 0);

    // Training converging in the second epoch
    err_limit = EW'(50);
    launch(1'b1);
    check("R5 train flag", train_busy, 1);
    send(30, 1'b0);
    send(40, 1'b1);
    check("R6 epoch total", last_err, 70);
    check("R6 epoch count", epoch_count, 1);
    check("R7 still training", train_busy, 1);
    // start while busy is ignored
    launch(1'b0);
    check("R5 start ignored busy", train_busy, 1);
    send(10, 1'b0);
    send(20, 1'b1);
    check("R6 sum restarted", last_err, 30);
    check("R7 converged", converged, 1);
    check("R7 idle", idle_flag, 1);
    check("R6 epoch count 2", epoch_count, 2);

    // Threshold is strict: total equal to limit does not converge
    err_limit = EW'(5);
    launch(1'b1);
    check("R8 verdicts cleared", {converged, not_converged}, 0);
    check("R8 epoch reset", epoch_count, 0);
    send(5, 1'b1);
    check("R7 equal not below", train_busy, 1);
    for (int k = 2; k <= MAXE; k++) begin
      send(100, 1'b1);
      if (k < MAXE) check("R8 continuing", epoch_count, k);
    end
    check("R8 not converged", not_converged, 1);
    check("R8 final count", epoch_count, MAXE);
    check("R8 idle", idle_flag, 1);
    check("R7 no converge", converged, 0);

    // Saturation
    launch(1'b1);
    send((1 << EW) - 1, 1'b0);
    send((1 << EW) - 1, 1'b1);
    check("R11 saturated total", last_err, (1 << EW) - 1);
    send(0, 1'b1);
    check("R11 cleared after epoch", last_err, 0);
    check("R7 converged on zero", converged, 1);

    // Asynchronous reset in mid-training
    launch(1'b1);
    send(7, 1'b0);
    @(negedge clk); #3;
    do_reset();
    check("R1 verdicts after re-init", {converged, not_converged}, 0);

    report();
  end

endmodule